// File: doc/BRIEF.md
# Arbitrated Shared-Line Serial Transmitter

This block is one sender on a serial wire that many senders share and one receiver listens to. Before it may drive the wire, it must win access from an external fixed-priority arbiter. The arbiter is reached through two active-low lines: a request that the node drives and a grant that the arbiter returns. The local logic hands the block a frame as a stream of bytes on a valid/ready interface and marks the final byte with a flag. The block raises its request and waits for the grant, with no limit on how long it waits. It then sends each byte as an asynchronous character with one start bit, eight data bits LSB first, no parity and one stop bit. After the last stop bit it lets go of the request.

The serial bit leaves the block together with an enable for the tri-state buffer in front of the wire. That enable is only on while the node holds both request and grant. The arbitration clock and the grant come from another clock domain, so the block passes each through two flip-flops. After every release of the request, the block counts rising edges of the synchronized arbitration clock before it may request again. This gives a cascade of arbiters time to drop the stale grant. If the grant goes away in the middle of a frame, the block holds the wire high for one more bit time, stops driving it, raises an error flag and returns to idle through the same holdoff.

Top module: `shared_uart_tx_node`

## Requirements
- R1: While rst_n is low, and right after it rises, req_n is 1, line_oe is 0, line_out is 1, tx_ready is 0 and frame_err is 0.
- R2: With the node idle and the holdoff over, tx_valid high makes req_n go to 0. No byte is accepted (tx_ready stays 0) and line_oe stays 0 until a grant has been seen.
- R3: While grant_n stays 1, the node keeps req_n at 0 for as long as it takes, with line_oe 0 and line_out 1.
- R4: grant_n passes through two local flip-flops. When grant_n falls between clock edges, line_oe rises at the third rising clk edge after that change, and line_oe never rises unless the synchronized grant was asserted on the cycle before.
- R5: Each byte goes out as a start bit (0), data bits 0 to 7 in that order, and a stop bit (1). Each bit lasts baud_div clk cycles (baud_div at least 1).
- R6: Bytes move only on cycles where tx_valid and tx_ready are both 1, and tx_ready is only 1 while line_oe is 1. req_n stays 0 between the bytes of a frame. After the stop bit of a byte sent with tx_last = 1, req_n returns to 1 and line_oe to 0.
- R7: Whenever line_oe is 0, line_out is 1.
- R8: After each release of req_n, req_n stays 1 until TIERS+1 rising edges of the synchronized arb_clk have been counted. This is at least TIERS full arbitration periods.
- R9: If the synchronized grant drops during a frame, line_out is held at 1 with line_oe on for baud_div cycles. Then line_oe goes to 0, req_n to 1 and frame_err to 1. frame_err stays 1 until the next request begins, which clears it.
- R10: line_oe is never 1 while req_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_clk | input | 1 | Arbitration clock, asynchronous to clk |
| grant_n | input | 1 | Grant from the arbiter, active low |
| req_n | output | 1 | Request to the arbiter, active low |
| baud_div | input | DIV_W | Bit period in clk cycles |
| tx_data | input | 8 | Byte offered for sending |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_last | input | 1 | Offered byte ends the frame |
| tx_ready | output | 1 | Byte is taken on this cycle when tx_valid is also high |
| line_out | output | 1 | Serial bit toward the tri-state driver |
| line_oe | output | 1 | Enable for the tri-state driver |
| frame_err | output | 1 | Last frame ended by grant loss |

## Verification
Two things can line up in the same cycle: the holdoff expiring and a new frame already waiting on tx_valid. The bench sets this up by queuing the next frame straight behind the previous one. It then measures the cycles from the rise of req_n to its fall against the arbitration period times TIERS. The other overlap is grant removal in the middle of a character while more bytes are still offered. The bench causes it by denying the grant in its arbiter model partway through the second byte. It then checks that the line stays high for at least a bit time before the enable drops, that no further byte is taken, and that the error flag holds until the next request.

// File: rtl/shared_uart_tx_node.sv
module shared_uart_tx_node #(
  parameter int TIERS = 1,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_clk,
  input  logic             grant_n,
  output logic             req_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  input  logic             tx_last,
  output logic             tx_ready,
  output logic             line_out,
  output logic             line_oe,
  output logic             frame_err
);

  localparam int HW = $clog2(TIERS + 2);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_SEND, S_DRAIN, S_HOLD} st_t;

  st_t              st;
  logic [2:0]       arb_q;
  logic [1:0]       gnt_q;
  logic [9:0]       sh;
  logic [3:0]       bits;
  logic [DIV_W-1:0] cnt;
  logic             busy, last_q;
  logic [HW-1:0]    hcnt;

  wire arb_rise = arb_q[1] & ~arb_q[2];
  wire grant_s  = gnt_q[1];
  wire bit_end  = (cnt == '0);

  assign req_n    = !(st == S_REQ || st == S_SEND || st == S_DRAIN);
  assign line_oe  = (st == S_SEND || st == S_DRAIN);
  assign line_out = line_oe ? sh[0] : 1'b1;
  assign tx_ready = (st == S_SEND) && !busy && grant_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arb_q <= '0;
      gnt_q <= '0;
    end else begin
      arb_q <= {arb_q[1:0], arb_clk};
      gnt_q <= {gnt_q[0], ~grant_n};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      sh        <= '1;
      bits      <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      last_q    <= 1'b0;
      hcnt      <= '0;
      frame_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (tx_valid) begin
            st        <= S_REQ;
            frame_err <= 1'b0;
          end
        S_REQ:
          if (grant_s) begin
            st   <= S_SEND;
            busy <= 1'b0;
          end
        S_SEND:
          if (!grant_s) begin
            st   <= S_DRAIN;
            busy <= 1'b0;
            sh   <= '1;
            cnt  <= baud_div - 1'b1;
          end else if (!busy) begin
            if (tx_valid) begin
              busy   <= 1'b1;
              sh     <= {1'b1, tx_data, 1'b0};
              bits   <= 4'd10;
              cnt    <= baud_div - 1'b1;
              last_q <= tx_last;
            end
          end else if (bit_end) begin
            sh   <= {1'b1, sh[9:1]};
            bits <= bits - 1'b1;
            cnt  <= baud_div - 1'b1;
            if (bits == 4'd1) begin
              busy <= 1'b0;
              if (last_q) begin
                st   <= S_HOLD;
                hcnt <= '0;
              end
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_DRAIN:
          if (bit_end) begin
            st        <= S_HOLD;
            hcnt      <= '0;
            frame_err <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_HOLD:
          if (arb_rise) begin
            if (hcnt == HW'(TIERS)) st <= S_IDLE;
            else hcnt <= hcnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end

endmodule

// File: rtl/shared_uart_tx_node_chk.sv
module shared_uart_tx_node_chk #(
  parameter int TIERS = 1
) (
  input logic clk,
  input logic rst_n,
  input logic req_n,
  input logic line_oe,
  input logic line_out,
  input logic tx_ready,
  input logic frame_err,
  input logic grant_s,
  input logic arb_rise
);

  logic       req_q, seen_rel;
  logic [7:0] ecnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_q    <= 1'b1;
      seen_rel <= 1'b0;
      ecnt     <= '0;
    end else begin
      req_q <= req_n;
      if (req_n && !req_q) begin
        seen_rel <= 1'b1;
        ecnt     <= arb_rise ? 8'd1 : 8'd0;
      end else if (req_n && arb_rise && ecnt != 8'hFF) begin
        ecnt <= ecnt + 1'b1;
      end
    end

  p_oe_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !req_n);

  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> line_out);

  p_drive_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(grant_s));

  p_ready_only_driving_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> line_oe);

  p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_n) && seen_rel) |-> (ecnt >= 8'(TIERS + 1)));

  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> (req_n && !line_oe));

endmodule

bind shared_uart_tx_node shared_uart_tx_node_chk #(.TIERS(TIERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .line_oe(line_oe),
  .line_out(line_out), .tx_ready(tx_ready), .frame_err(frame_err),
  .grant_s(grant_s), .arb_rise(arb_rise)
);

// File: tb/test_shared_uart_tx_node.sv
`timescale 1ns/1ps
module test_shared_uart_tx_node;
  localparam int TIERS    = 2;
  localparam int DIV      = 8;
  localparam int ARB_HALF = 5;
  localparam int ARB_CYC  = 2 * ARB_HALF;

  logic clk = 0, rst_n = 0, arb_clk = 0, grant_n = 1;
  logic [15:0] baud_div = 16'(DIV);
  logic [7:0] tx_data = 0;
  logic tx_valid = 0, tx_last = 0;
  logic req_n, tx_ready, line_out, line_oe, frame_err;

  int tests = 0, fails = 0, cyc = 0, g_cyc = 0, ac = 0;
  bit deny = 0, mon_en = 1, abort = 0;
  logic [8:0] expq[$];

  shared_uart_tx_node #(.TIERS(TIERS), .DIV_W(16)) i_shared_uart_tx_node (
    .clk(clk), .rst_n(rst_n), .arb_clk(arb_clk), .grant_n(grant_n), .req_n(req_n),
    .baud_div(baud_div), .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .line_out(line_out), .line_oe(line_oe), .frame_err(frame_err));

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one-tier arbiter model: grant follows request at each arbitration edge
  always @(negedge clk) begin
    ac++;
    if (ac == ARB_HALF) begin
      ac = 0;
      arb_clk = ~arb_clk;
      if (arb_clk) begin
        if (grant_n && !(deny ? 1'b1 : req_n)) g_cyc = cyc;
        grant_n = deny ? 1'b1 : req_n;
      end
    end
  end

  // scoreboard monitor (R5, R6)
  always begin
    @(negedge clk);
    if (mon_en && line_oe && !line_out) begin
      logic [7:0] d;
      logic [8:0] e;
      logic st, sp;
      repeat (DIV/2) @(negedge clk);
      st = line_out;
      for (int i = 0; i < 8; i++) begin
        repeat (DIV) @(negedge clk);
        d[i] = line_out;
      end
      repeat (DIV) @(negedge clk);
      sp = line_out;
      if (expq.size() == 0) begin
        check(0, "R5 unexpected byte", d, -1);
      end else begin
        e = expq.pop_front();
        check(st == 0 && sp == 1, "R5 start/stop levels", {st, sp}, 1);
        check(d == e[7:0], "R5 data bits", d, e[7:0]);
        if (e[8]) begin
          repeat (DIV) @(negedge clk);
          check(req_n && !line_oe, "R6 release after last", {req_n, line_oe}, 2);
        end else begin
          check(!req_n && line_oe, "R6 request held mid-frame", {req_n, line_oe}, 1);
        end
      end
    end
  end

  // holdoff monitor (R8)
  always begin
    int r_cyc;
    bit had;
    logic pr;
    had = 0; pr = 1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (req_n && !pr) begin r_cyc = cyc; had = 1; end
        if (!req_n && pr && had)
          check(cyc - r_cyc >= TIERS * ARB_CYC, "R8 holdoff", cyc - r_cyc, TIERS * ARB_CYC);
      end
      pr = req_n;
    end
  end

  task automatic send_frame(input logic [7:0] b[8], input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_data = b[i]; tx_last = (i == n - 1); tx_valid = 1;
      while (!tx_ready && !abort) @(negedge clk);
      if (abort) break;
      @(posedge clk);
      if (mon_en) expq.push_back({tx_last, tx_data});
    end
    @(negedge clk);
    tx_valid = 0; tx_last = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", cyc, 150000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] f[8];
    repeat (5) @(negedge clk);
    check(req_n && !line_oe && line_out && !tx_ready && !frame_err, "R1 in reset",
          {req_n, line_oe, line_out, tx_ready, frame_err}, 5'b10100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(req_n && !line_oe && line_out && !tx_ready && !frame_err, "R1 after reset",
          {req_n, line_oe, line_out, tx_ready, frame_err}, 5'b10100);

    // R2/R3: grant withheld for a long time
    deny = 1;
    tx_data = 8'hA5; tx_last = 1; tx_valid = 1;
    repeat (300) @(negedge clk);
    check(!req_n, "R2 request asserted", req_n, 0);
    check(!line_oe && !tx_ready && line_out, "R3 waiting, not driving",
          {line_oe, tx_ready, line_out}, 1);
    deny = 0;
    while (!line_oe) @(negedge clk);
    check(cyc - g_cyc == 3, "R4 grant to enable latency", cyc - g_cyc, 3);
    tx_valid = 0;
    f[0] = 8'hA5;
    send_frame(f, 1);
    while (expq.size() != 0) @(negedge clk);

    // several patterns, frames queued back to back (R5, R6, R8)
    f[0] = 8'h00; f[1] = 8'hFF; f[2] = 8'h55; f[3] = 8'h81;
    send_frame(f, 4);
    f[0] = 8'h3C;
    send_frame(f, 1);
    f[0] = 8'hC3; f[1] = 8'h01;
    send_frame(f, 2);
    while (expq.size() != 0) @(negedge clk);
    repeat (4 * DIV) @(negedge clk);
    check(req_n && !line_oe && line_out, "R7 idle line high", {req_n, line_oe, line_out}, 5);

    // R9: grant lost mid-frame
    mon_en = 0; abort = 0;
    fork
      begin
        f[0] = 8'h12; f[1] = 8'h34; f[2] = 8'h56;
        send_frame(f, 3);
      end
      begin
        int hi;
        while (!line_oe) @(negedge clk);
        repeat (15 * DIV) @(negedge clk);
        deny = 1;
        hi = 0;
        while (line_oe) begin
          @(negedge clk);
          if (line_oe) hi = line_out ? hi + 1 : 0;
        end
        check(hi >= DIV - 1, "R9 stop level held before release", hi, DIV);
        check(!tx_ready, "R9 no byte taken after loss", tx_ready, 0);
        @(negedge clk);
        check(frame_err && req_n, "R9 error flagged, request dropped", {frame_err, req_n}, 3);
        abort = 1;
      end
    join
    repeat (100) @(negedge clk);
    check(frame_err && req_n && !line_oe, "R9 error held while idle", {frame_err, req_n, line_oe}, 6);
    abort = 0; deny = 0; mon_en = 1;
    f[0] = 8'h7E;
    send_frame(f, 1);
    while (expq.size() != 0) @(negedge clk);
    check(!frame_err, "R9 error cleared by new request", frame_err, 0);

    repeat (20) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule